// File: doc/BRIEF.md
# Temperature-Sensor Poll Scheduler

This block decides when the memory-module temperature sensors are read, and which one is read next. A free-running down-counter sets the poll period. Each time the counter reaches zero while polling is on, the block raises a read request towards a shared SMBus master. The request names the next populated sensor slot in a fixed rotation. The SMBus master performs the transfer and answers with a single-cycle done. The block only sequences requests; it does not decode sensor data or run the bus protocol.

An 8-bit population mask covers two channels of up to three slots each. Software can overwrite the counter at any time, and writing zero makes the counter reload from its period value. The block also drives the select that gives the SMBus either to the poller or to software commands. Changes to that select are held back until no poll request is outstanding.

Top module: `tps_poll_sched`

## Requirements
- R1: While `rst_n` is low, each clock edge loads `cnt_value` with `rate_reload`, and the outputs sit at `req_valid`=0, `drained`=1 and `poll_active`=0.
- R2: When `cnt_wr` is low, the counter moves from a non-zero value to that value minus one on the next clock. From zero it reloads `rate_reload` on the next clock. With prompt done responses, successive requests therefore start `rate_reload`+1 cycles apart.
- R3: When `cnt_wr` is high, the counter takes `cnt_wr_data` on the next clock. If `cnt_wr_data` is zero, it takes `rate_reload` instead.
- R4: `poll_active` is the bus select: 1 means the poller owns the SMBus and 0 means software commands do. It follows `poll_en_req` only on clocks where `drained` is 1. No request is issued unless both `poll_active` and `poll_en_req` are 1.
- R5: An expiry issues a request on the next clock. An expiry is a clock where the counter is zero, `cnt_wr` is low, polling is on per R4, no request is outstanding and at least one valid slot is populated. The request targets the next populated mask bit after the last one served, searching upward from bit 0 to bit 6 and wrapping around. The first search after reset starts at bit 0. The output `req_chan` is mask bit index bit 2, and `req_slot` is index bits 1:0.
- R6: Mask bits 3 and 7 stand for an unsupported slot 3. They are ignored, and `req_slot` never equals 3.
- R7: While `req_valid` is 1, `req_slot` and `req_chan` stay constant. `req_valid` falls on the clock after `req_done` is seen high.
- R8: An expiry that occurs while a request is outstanding, including the clock where done arrives, is dropped. It is not queued, so the rotation advances by only one slot per served request.
- R9: If no valid slot is populated, no request is issued, and the counter keeps counting and reloading.
- R10: `drained` is 1 exactly when no poll request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poll_en_req | input | 1 | Requested polling mode (1 = poll) |
| present_mask | input | 8 | Slot population, bits 2:0 lower channel, 6:4 upper channel |
| rate_reload | input | 18 | Poll period reload value |
| cnt_wr | input | 1 | Software write strobe to the counter |
| cnt_wr_data | input | 18 | Value written to the counter |
| req_done | input | 1 | SMBus master finished the read |
| req_valid | output | 1 | Read request outstanding |
| req_slot | output | 2 | Slot number within the channel |
| req_chan | output | 1 | Channel, 0 lower, 1 upper |
| poll_active | output | 1 | Bus select, 1 = poller owns SMBus |
| drained | output | 1 | No poll request outstanding |
| cnt_value | output | 18 | Current counter value |

## Verification
The assertions assume that `present_mask` does not change while a request is outstanding, and that `req_done` is only raised while `req_valid` is high. The bench changes the mask only when `drained` is high. It pulses done for exactly one cycle, and only after it has seen a request. Mode changes are requested both with a request outstanding and with none, so that the deferral path is exercised within these limits.

// File: rtl/tps_pkg.sv
// Package: shared constants for the temperature-sensor poll scheduler.
// Assumes a mask of two channels, each with a 4-position field whose top
// position is reserved.
package tps_pkg;
    localparam int MASK_W  = 8;                  // population mask width
    localparam int GRP_W   = 4;                  // positions per channel field
    localparam int IDX_W   = $clog2(MASK_W);     // mask bit index width
    localparam int SLOT_W  = $clog2(GRP_W);      // slot number width
    typedef logic [IDX_W-1:0] idx_t;
endpackage

// File: rtl/tps_rate_cnt.sv
// Module: poll-period down-counter.
// Counts down once per clock. It reloads from the period input on reset,
// on reaching zero, and on a software write of zero. A non-zero write is
// taken directly. Every change appears on the following clock. Assumes the
// period input is stable during reset.
module tps_rate_cnt #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reload,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    // Counter register: reset/write/zero reload, else decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= reload;
        else if (wr)
            cnt <= (wr_data == '0) ? reload : wr_data;
        else if (cnt == '0)
            cnt <= reload;
        else
            cnt <= cnt - 1'b1;
    end

    // Expiry pulse: zero reached and not overridden by a write this cycle.
    always_comb expire = (cnt == '0) && !wr;
endmodule

// File: rtl/tps_slot_pick.sv
// Module: round-robin picker over the population mask.
// Clears the reserved top position of each channel field. It then returns
// the first set bit after the last served index, wrapping around. Purely
// combinational. Assumes the last index is a legal mask bit index.
module tps_slot_pick
    import tps_pkg::*;
(
    input  logic [MASK_W-1:0] mask,
    input  idx_t              last_idx,
    output logic              any,
    output idx_t              next_idx
);
    logic [MASK_W-1:0] legal;
    logic [MASK_W-1:0] eff;

    // Legal-position mask: every position except the last of each field.
    for (genvar g = 0; g < MASK_W; g++) begin : g_legal
        assign legal[g] = ((g % GRP_W) != (GRP_W - 1));
    end

    // Effective population after dropping reserved positions.
    always_comb eff = mask & legal;

    // Circular search for the first populated index after last_idx.
    always_comb begin
        any      = 1'b0;
        next_idx = last_idx;
        for (int k = 1; k <= MASK_W; k++) begin
            idx_t cand;
            cand = idx_t'((int'(last_idx) + k) % MASK_W);
            if (!any && eff[cand]) begin
                any      = 1'b1;
                next_idx = cand;
            end
        end
    end
endmodule

// File: rtl/tps_mode_ctl.sv
// Module: bus-ownership select between poller and software commands.
// The requested mode is adopted only while no poll request is outstanding.
// Assumes the drained input reflects the request register of the same cycle.
module tps_mode_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_req,
    input  logic drained,
    output logic active
);
    // Mode register: follow the request only when drained.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= 1'b0;
        else if (drained)
            active <= mode_req;
    end
endmodule

// File: rtl/tps_poll_sched.sv
// Module: temperature-sensor poll scheduler (top).
// Combines the period counter, the slot picker and the mode select. On
// each expiry with polling on and nothing outstanding, it raises one
// request to the next populated slot and holds it until done. Expiries
// that arrive while a request is outstanding are dropped. Assumes done is
// raised only while a request is valid, and that the mask is stable while
// a request is outstanding.
module tps_poll_sched
    import tps_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    poll_en_req,
    input  logic [MASK_W-1:0]       present_mask,
    input  logic [CNT_W-1:0]        rate_reload,
    input  logic                    cnt_wr,
    input  logic [CNT_W-1:0]        cnt_wr_data,
    input  logic                    req_done,
    output logic                    req_valid,
    output logic [SLOT_W-1:0]       req_slot,
    output logic                    req_chan,
    output logic                    poll_active,
    output logic                    drained,
    output logic [CNT_W-1:0]        cnt_value
);
    logic expire;
    logic any_slot;
    logic issue;
    idx_t last_idx;
    idx_t next_idx;
    idx_t req_idx;

    tps_rate_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (rate_reload),
        .wr      (cnt_wr),
        .wr_data (cnt_wr_data),
        .cnt     (cnt_value),
        .expire  (expire)
    );

    tps_slot_pick u_pick (
        .mask     (present_mask),
        .last_idx (last_idx),
        .any      (any_slot),
        .next_idx (next_idx)
    );

    tps_mode_ctl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_req (poll_en_req),
        .drained  (drained),
        .active   (poll_active)
    );

    // No request outstanding.
    always_comb drained = !req_valid;

    // Issue decision: a pending turn-off request suppresses new polls.
    always_comb issue = expire && poll_active && poll_en_req && drained && any_slot;

    // Request register and round-robin pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_idx   <= '0;
            last_idx  <= idx_t'(MASK_W - 1);
        end else if (req_valid && req_done) begin
            req_valid <= 1'b0;
        end else if (issue) begin
            req_valid <= 1'b1;
            req_idx   <= next_idx;
            last_idx  <= next_idx;
        end
    end

    // Split the mask index into channel and slot.
    always_comb begin
        req_slot = req_idx[SLOT_W-1:0];
        req_chan = req_idx[IDX_W-1];
    end
endmodule

// File: rtl/tps_poll_sched_chk.sv
// Module: property checker for the poll scheduler, bound to the top.
// Assumes done only while a request is valid and a mask stable during requests.
module tps_poll_sched_chk
    import tps_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input logic                clk,
    input logic                rst_n,
    input logic                poll_en_req,
    input logic [MASK_W-1:0]   present_mask,
    input logic [CNT_W-1:0]    rate_reload,
    input logic                cnt_wr,
    input logic [CNT_W-1:0]    cnt_wr_data,
    input logic                req_done,
    input logic                req_valid,
    input logic [SLOT_W-1:0]   req_slot,
    input logic                req_chan,
    input logic                poll_active,
    input logic                drained,
    input logic [CNT_W-1:0]    cnt_value
);
    // R2: decrement from non-zero without a write
    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && cnt_value != '0) |=> (cnt_value == $past(cnt_value) - 1'b1));

    // R2: reload after reaching zero
    a_r2_zero_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && cnt_value == '0) |=> (cnt_value == $past(rate_reload)));

    // R3: write of zero reloads the period
    a_r3_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && cnt_wr_data == '0) |=> (cnt_value == $past(rate_reload)));

    // R4: mode select changes only while drained
    a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !drained |=> $stable(poll_active));

    // R4: a new request only starts under polling ownership
    a_r4_rise_active: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> poll_active);

    // R5: the addressed slot is populated
    a_r5_present: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> present_mask[{req_chan, req_slot}]);

    // R6: reserved slot never addressed
    a_r6_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_slot != SLOT_W'(GRP_W - 1)));

    // R7: request held stable until done
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_done) |=> (req_valid && $stable(req_slot) && $stable(req_chan)));

    // R7: request drops after done
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_done) |=> !req_valid);
endmodule

bind tps_poll_sched tps_poll_sched_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .poll_en_req  (poll_en_req),
    .present_mask (present_mask),
    .rate_reload  (rate_reload),
    .cnt_wr       (cnt_wr),
    .cnt_wr_data  (cnt_wr_data),
    .req_done     (req_done),
    .req_valid    (req_valid),
    .req_slot     (req_slot),
    .req_chan     (req_chan),
    .poll_active  (poll_active),
    .drained      (drained),
    .cnt_value    (cnt_value)
);

// File: tb/tps_poll_sched_bench.sv
// Bench: directed scenarios for the poll scheduler, one task each.
module tps_poll_sched_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 18;
    localparam int RELOAD     = 20;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             poll_en_req;
    logic [7:0]       present_mask;
    logic [CNT_W-1:0] rate_reload;
    logic             cnt_wr;
    logic [CNT_W-1:0] cnt_wr_data;
    logic             req_done;
    logic             req_valid;
    logic [1:0]       req_slot;
    logic             req_chan;
    logic             poll_active;
    logic             drained;
    logic [CNT_W-1:0] cnt_value;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit ended = 1'b0;

    tps_poll_sched #(.CNT_W(CNT_W)) u_tps_poll_sched (
        .clk(clk), .rst_n(rst_n), .poll_en_req(poll_en_req),
        .present_mask(present_mask), .rate_reload(rate_reload),
        .cnt_wr(cnt_wr), .cnt_wr_data(cnt_wr_data), .req_done(req_done),
        .req_valid(req_valid), .req_slot(req_slot), .req_chan(req_chan),
        .poll_active(poll_active), .drained(drained), .cnt_value(cnt_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Wait for a request; returns the mask index and the cycle it was seen.
    task automatic wait_req(output int idx, output int at, output bit seen);
        seen = 1'b0;
        idx  = -1;
        at   = 0;
        for (int i = 0; i < 400 && !seen; i++) begin
            @(negedge clk);
            if (req_valid) begin
                seen = 1'b1;
                idx  = {req_chan, req_slot};
                at   = cyc;
            end
        end
    endtask

    // One-cycle done pulse, then confirm release.
    task automatic give_done();
        req_done = 1'b1;
        @(negedge clk);
        req_done = 1'b0;
        check(!req_valid && drained, "R7 release after done", int'(req_valid), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(cnt_value == RELOAD, "R1 counter loaded", int'(cnt_value), RELOAD);
        check(!req_valid && drained, "R1 idle request", int'(req_valid), 0);
        check(!poll_active, "R1 software owns bus", int'(poll_active), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_count();
        int v;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            v = int'(cnt_value);
            @(negedge clk);
            check(int'(cnt_value) == ((v == 0) ? RELOAD : v - 1), "R2 decrement", int'(cnt_value), (v == 0) ? RELOAD : v - 1);
        end
        for (int i = 0; i < 100 && cnt_value != 0; i++) @(negedge clk);
        @(negedge clk);
        check(cnt_value == RELOAD, "R2 reload at zero", int'(cnt_value), RELOAD);
    endtask

    task automatic t_write();
        cnt_wr = 1'b1; cnt_wr_data = '0;
        @(negedge clk);
        check(cnt_value == RELOAD, "R3 zero write reloads", int'(cnt_value), RELOAD);
        cnt_wr_data = 18'd7;
        @(negedge clk);
        cnt_wr = 1'b0;
        check(cnt_value == 7, "R3 value written", int'(cnt_value), 7);
        @(negedge clk);
        check(cnt_value == 6, "R3 counts after write", int'(cnt_value), 6);
    endtask

    // Rotation with period check; the first request only sets the time base.
    task automatic t_robin(input logic [7:0] mask, input int exp_seq[], input string tag);
        int idx, at, prev;
        bit seen;
        present_mask = mask;
        poll_en_req  = 1'b1;
        prev = -1;
        foreach (exp_seq[i]) begin
            wait_req(idx, at, seen);
            check(seen && idx == exp_seq[i], tag, idx, exp_seq[i]);
            check(idx[1:0] != 2'd3, "R6 reserved slot skipped", idx, exp_seq[i]);
            check(!drained, "R10 busy while outstanding", int'(drained), 0);
            if (prev >= 0)
                check(at - prev == RELOAD + 1, "R2 poll interval", at - prev, RELOAD + 1);
            prev = at;
            @(negedge clk);
            check(req_valid && {req_chan, req_slot} == exp_seq[i], "R7 held stable", int'({req_chan, req_slot}), exp_seq[i]);
            give_done();
        end
    endtask

    task automatic t_empty();
        bit any_req = 1'b0;
        bit moved = 1'b0;
        int v0;
        present_mask = 8'h88;
        v0 = int'(cnt_value);
        for (int i = 0; i < 3 * (RELOAD + 1); i++) begin
            @(negedge clk);
            if (req_valid) any_req = 1'b1;
            if (int'(cnt_value) != v0) moved = 1'b1;
        end
        check(!any_req, "R9 no request on empty mask", int'(any_req), 0);
        check(moved, "R9 counter keeps running", int'(moved), 1);
    endtask

    task automatic t_drop();
        int idx, at;
        bit seen;
        present_mask = 8'h77;
        wait_req(idx, at, seen);
        check(seen && idx == 4, "R5 next after slot index 2", idx, 4);
        repeat (3 * (RELOAD + 1)) @(negedge clk);
        check(req_valid && {req_chan, req_slot} == 3'd4, "R8 held across expiries", int'({req_chan, req_slot}), 4);
        give_done();
        wait_req(idx, at, seen);
        check(seen && idx == 5, "R8 single advance", idx, 5);
        give_done();
    endtask

    task automatic t_mode();
        int idx, at;
        bit seen;
        bit any_req = 1'b0;
        wait_req(idx, at, seen);
        check(seen && idx == 6, "R5 rotation continues", idx, 6);
        poll_en_req = 1'b0;
        @(negedge clk);
        check(poll_active, "R4 change held back", int'(poll_active), 1);
        check(!drained, "R10 not drained", int'(drained), 0);
        give_done();
        @(negedge clk);
        check(!poll_active, "R4 change after drain", int'(poll_active), 0);
        for (int i = 0; i < 2 * (RELOAD + 1); i++) begin
            @(negedge clk);
            if (req_valid) any_req = 1'b1;
        end
        check(!any_req, "R4 no poll under software", int'(any_req), 0);
    endtask

    initial begin
        poll_en_req  = 1'b0;
        present_mask = 8'h00;
        rate_reload  = RELOAD;
        cnt_wr       = 1'b0;
        cnt_wr_data  = '0;
        req_done     = 1'b0;
        rst_n        = 1'b0;
        @(negedge clk);
        t_reset();
        t_count();
        t_write();
        t_robin(8'h77, '{0, 1, 2, 4, 5, 6, 0}, "R5 full rotation");
        t_robin(8'hAC, '{2, 5, 2}, "R6 mask with reserved bits");
        t_empty();
        t_drop();
        t_mode();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule